// File: doc/BRIEF.md
# Radar Pulse Timing Controller

This block derives the per-pulse timing of a pulsed radar from a free-running sample clock. A counter runs through one pulse repetition period (PRT) after another. From its phase the block produces a one-cycle strobe at the start of each period, a trigger for an external transmit amplifier, and a receive gate that opens a window of programmed position and length. Receive samples arrive on a valid/ready stream. Inside the window they pass straight through and follow the downstream back-pressure. Outside the window they are accepted and discarded.

Pulses are counted in groups of a programmable size. The first pulse of every group raises a one-cycle interrupt request and sets a sticky flag, which software clears by writing one to it. The block also reports the number of receive samples a group delivers to memory. This figure depends on the group size, the per-pulse sample count, and whether the decimate-by-6 filter path is selected. Configuration enters through a plain write port into staging registers. The staged values are copied into the working set only at a period boundary, or when the sequence starts.

Top module: `radar_pulse_timer`

## Requirements
- R1: Write-port register addresses are: 0 period, 1 trigger offset, 2 trigger width, 3 gate delay, 4 samples per pulse, 5 group size, 6 control (bit 0 run, bit 1 filter select), 7 status (bit 0 sticky interrupt, write one to clear). With run set and a legal configuration, `prt_strobe` is high for exactly one cycle per period and rises every PRT cycles.
- R2: Let the pulse phase be the cycle count since the strobe, with the strobe cycle as phase 0. `amp_trig` is high exactly for phases in [offset, offset+width).
- R3: `rx_gate` is high exactly for phases in [delay, delay+samples). While the gate is low, `rx_out_valid` is 0 and `rx_in_ready` is 1, so samples are dropped.
- R4: While the gate is high, `rx_out_valid` equals `rx_in_valid`, `rx_in_ready` equals `rx_out_ready`, and `rx_out_data` equals `rx_in_data`.
- R5: `irq` is a one-cycle pulse coincident with the strobe of pulses 0, N, 2N, and so on. The group count restarts whenever run takes the sequence from idle, so the first pulse after a start always raises `irq`.
- R6: `irq_flag` sets on the cycle after `irq`. A write of 1 to status bit 0 clears it. A write of 0 leaves it unchanged.
- R7: `xfer_len` equals N × samples with the filter off, and N × floor(samples / 6) with it on.
- R8: Writes go to staging registers. They take effect only at the next period boundary, or at start. The pulse in progress and `xfer_len` are unaffected until then.
- R9: Clearing run lets the current period finish, then stops the sequence. While stopped, strobe, trigger and gate stay low. After reset all outputs are 0.
- R10: The configuration is illegal if the period is < 2, N = 0, offset+width > period, or delay+samples > period. In that case `cfg_error` is 1, and strobe, trigger, gate and `irq` stay low while the timer keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| rx_in_valid | input | 1 | Receive sample valid |
| rx_in_ready | output | 1 | Receive sample accepted |
| rx_in_data | input | DATA_W | Receive sample |
| rx_out_valid | output | 1 | Gated sample valid |
| rx_out_ready | input | 1 | Downstream ready |
| rx_out_data | output | DATA_W | Gated sample |
| prt_strobe | output | 1 | Start-of-period strobe |
| amp_trig | output | 1 | Transmit amplifier trigger |
| rx_gate | output | 1 | Receive window |
| irq | output | 1 | Group-start interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| cfg_error | output | 1 | Working configuration illegal |
| xfer_len | output | 2*CNT_W | Samples delivered per group |

## Verification
Full periods are walked phase by phase with the sample stream held valid and downstream ready toggling every cycle. This separates pass-through from drop and shows that back-pressure reaches the input only inside the window. The group size of 3 is run across seven pulses, which tells the interrupt pattern apart from an every-pulse or never-repeat pulse. A stop taken while the group count is non-zero shows whether that count restarts. Writes landed mid-pulse show whether the trigger phase and transfer length wait for the boundary. An offset plus width beyond the period shows whether an illegal setting silences every output.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [2:0] {
    REG_PRT      = 3'd0,
    REG_TRIG_OFF = 3'd1,
    REG_TRIG_WID = 3'd2,
    REG_GATE_DLY = 3'd3,
    REG_RX_LEN   = 3'd4,
    REG_GROUP    = 3'd5,
    REG_CTRL     = 3'd6,
    REG_STATUS   = 3'd7
  } reg_addr_e;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_FILT_BIT  = 1;
  localparam int STATUS_IRQ_BIT = 0;
  localparam int NUM_WIN        = 2;
endpackage

// File: rtl/rpt_cfg_regs.sv
module rpt_cfg_regs
  import rpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic          load,
  output logic          run_req,
  output logic [CW-1:0] a_prt,
  output logic [CW-1:0] a_toff,
  output logic [CW-1:0] a_tw,
  output logic [CW-1:0] a_gd,
  output logic [CW-1:0] a_len,
  output logic [CW-1:0] a_grp,
  output logic          a_filt,
  output logic          err,
  output logic          irq_clr
);
  logic [CW-1:0] s_prt, s_toff, s_tw, s_gd, s_len, s_grp;
  logic          s_filt, s_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_prt <= '0; s_toff <= '0; s_tw <= '0; s_gd <= '0;
      s_len <= '0; s_grp <= '0; s_filt <= 1'b0; run_req <= 1'b0;
    end else if (we) begin
      case (addr)
        REG_PRT:      s_prt  <= wdata;
        REG_TRIG_OFF: s_toff <= wdata;
        REG_TRIG_WID: s_tw   <= wdata;
        REG_GATE_DLY: s_gd   <= wdata;
        REG_RX_LEN:   s_len  <= wdata;
        REG_GROUP:    s_grp  <= wdata;
        REG_CTRL: begin
          run_req <= wdata[CTRL_RUN_BIT];
          s_filt  <= wdata[CTRL_FILT_BIT];
        end
        default: ;
      endcase
    end
  end

  assign irq_clr = we && (addr == REG_STATUS) && wdata[STATUS_IRQ_BIT];

  always_comb begin
    s_bad = (s_prt < CW'(2)) || (s_grp == '0)
         || (({1'b0, s_toff} + {1'b0, s_tw}) > {1'b0, s_prt})
         || (({1'b0, s_gd} + {1'b0, s_len}) > {1'b0, s_prt});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_prt <= '0; a_toff <= '0; a_tw <= '0; a_gd <= '0;
      a_len <= '0; a_grp <= '0; a_filt <= 1'b0; err <= 1'b0;
    end else if (load) begin
      a_prt <= s_prt; a_toff <= s_toff; a_tw <= s_tw; a_gd <= s_gd;
      a_len <= s_len; a_grp <= s_grp; a_filt <= s_filt; err <= s_bad;
    end
  end
endmodule

// File: rtl/rpt_timer.sv
module rpt_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic [CW-1:0] prt,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic          load,
  output logic          pulse_start
);
  logic boundary;

  assign boundary    = ({1'b0, cnt} + 1'b1) >= {1'b0, prt};
  assign load        = run_req && (!running || boundary);
  assign pulse_start = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= run_req;
      cnt     <= '0;
    end else if (boundary) begin
      running <= run_req;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && prt >= CW'(2)) |-> (cnt < prt));
endmodule

// File: rtl/rpt_window.sv
module rpt_window #(
  parameter int CW = 16
) (
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  output logic          active
);
  assign active = en && (cnt >= start)
               && ({1'b0, cnt} < ({1'b0, start} + {1'b0, len}));
endmodule

// File: rtl/rpt_group.sv
module rpt_group #(
  parameter int CW    = 16,
  parameter int DECIM = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            pulse_start,
  input  logic            ok,
  input  logic [CW-1:0]   grp_n,
  input  logic [CW-1:0]   rx_len,
  input  logic            filt,
  input  logic            irq_clr,
  output logic            irq,
  output logic            irq_flag,
  output logic [2*CW-1:0] xfer_len
);
  localparam int XW = 2 * CW;
  localparam logic [CW-1:0] DIV = CW'(DECIM);

  logic [CW-1:0] grp;
  logic [CW-1:0] per_pulse;

  assign irq = pulse_start && ok && (grp == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      grp <= '0;
    end else if (pulse_start && ok) begin
      grp <= (({1'b0, grp} + 1'b1) >= {1'b0, grp_n}) ? '0 : grp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (irq)     irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign per_pulse = filt ? (rx_len / DIV) : rx_len;
  assign xfer_len  = XW'(grp_n) * XW'(per_pulse);

  assert_irq_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pulse_start);
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq_flag);
endmodule

// File: rtl/radar_pulse_timer.sv
module radar_pulse_timer
  import rpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int DECIM  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [CNT_W-1:0]   cfg_wdata,
  input  logic               rx_in_valid,
  output logic               rx_in_ready,
  input  logic [DATA_W-1:0]  rx_in_data,
  output logic               rx_out_valid,
  input  logic               rx_out_ready,
  output logic [DATA_W-1:0]  rx_out_data,
  output logic               prt_strobe,
  output logic               amp_trig,
  output logic               rx_gate,
  output logic               irq,
  output logic               irq_flag,
  output logic               cfg_error,
  output logic [2*CNT_W-1:0] xfer_len
);
  logic             run_req, a_filt, err, irq_clr;
  logic [CNT_W-1:0] a_prt, a_toff, a_tw, a_gd, a_len, a_grp;
  logic             running, load, pulse_start, ok;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win_start [NUM_WIN];
  logic [CNT_W-1:0] win_len   [NUM_WIN];
  logic [NUM_WIN-1:0] win_act;

  rpt_cfg_regs #(.CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .run_req(run_req), .a_prt(a_prt), .a_toff(a_toff), .a_tw(a_tw),
    .a_gd(a_gd), .a_len(a_len), .a_grp(a_grp), .a_filt(a_filt), .err(err),
    .irq_clr(irq_clr)
  );

  rpt_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .prt(a_prt),
    .running(running), .cnt(cnt), .load(load), .pulse_start(pulse_start)
  );

  assign ok = running && !err;

  assign win_start[0] = a_toff;
  assign win_len[0]   = a_tw;
  assign win_start[1] = a_gd;
  assign win_len[1]   = a_len;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    rpt_window #(.CW(CNT_W)) u_win (
      .en(ok), .cnt(cnt), .start(win_start[w]), .len(win_len[w]),
      .active(win_act[w])
    );
  end

  rpt_group #(.CW(CNT_W), .DECIM(DECIM)) u_group (
    .clk(clk), .rst_n(rst_n), .restart(load && !running),
    .pulse_start(pulse_start), .ok(ok), .grp_n(a_grp), .rx_len(a_len),
    .filt(a_filt), .irq_clr(irq_clr), .irq(irq), .irq_flag(irq_flag),
    .xfer_len(xfer_len)
  );

  assign prt_strobe   = pulse_start && !err;
  assign amp_trig     = win_act[0];
  assign rx_gate      = win_act[1];
  assign cfg_error    = err;
  assign rx_out_valid = rx_in_valid && rx_gate;
  assign rx_in_ready  = rx_gate ? rx_out_ready : 1'b1;
  assign rx_out_data  = rx_in_data;

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prt_strobe |=> !prt_strobe);
  assert_drop_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_gate |-> (!rx_out_valid && rx_in_ready));
  assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gate |-> (rx_in_ready == rx_out_ready));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!prt_strobe && !amp_trig && !rx_gate));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (!prt_strobe && !amp_trig && !rx_gate && !irq));
endmodule

// File: tb/tb_radar_pulse_timer.sv
module tb_radar_pulse_timer;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          rx_in_valid = 1'b0;
  logic          rx_in_ready;
  logic [DW-1:0] rx_in_data = '0;
  logic          rx_out_valid;
  logic          rx_out_ready = 1'b0;
  logic [DW-1:0] rx_out_data;
  logic          prt_strobe, amp_trig, rx_gate, irq, irq_flag, cfg_error;
  logic [2*CW-1:0] xfer_len;

  int checks = 0;
  int errors = 0;
  int e_prt = 20, e_toff = 2, e_tw = 3, e_gd = 5, e_len = 8;

  radar_pulse_timer #(.CNT_W(CW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid),
    .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .prt_strobe(prt_strobe), .amp_trig(amp_trig), .rx_gate(rx_gate), .irq(irq),
    .irq_flag(irq_flag), .cfg_error(cfg_error), .xfer_len(xfer_len)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (prt_strobe) return;
    end
    check(1'b0, "R1", "strobe never seen", 0, 1);
  endtask

  task automatic idle_window(input int n, input string req, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (prt_strobe || amp_trig || rx_gate || irq || rx_out_valid) bad++;
    end
    check(bad == 0, req, what, bad, 0);
  endtask

  // Walks one period starting at the strobe cycle (phase 0).
  task automatic measure_pulse(input bit do_wr, input logic [2:0] wa, input int wd,
                               input bit exp_irq, input int exp_xfer, input bit exp_next);
    int tbad = 0, gbad = 0, sbad = 0, ibad = 0;
    bit et, eg;
    for (int k = 0; k < e_prt; k++) begin
      if (k > 0) @(negedge clk);
      if (do_wr && k == 1) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = CW'(wd); end
      if (k == 2) cfg_we = 1'b0;
      rx_in_valid  = 1'b1;
      rx_out_ready = k[0];
      rx_in_data   = DW'(k * 3 + 7);
      #1;
      if (k == 0) begin
        check(prt_strobe == 1'b1, "R1", "strobe at phase 0", prt_strobe, 1);
        check(irq == exp_irq, "R5", "irq at phase 0", irq, exp_irq);
        check(xfer_len == 32'(exp_xfer), "R7", "xfer_len", xfer_len, exp_xfer);
      end else begin
        if (prt_strobe) sbad++;
        if (irq) ibad++;
      end
      et = (k >= e_toff) && (k < e_toff + e_tw);
      eg = (k >= e_gd) && (k < e_gd + e_len);
      if (amp_trig !== et) tbad++;
      if (rx_gate !== eg) gbad++;
      if (rx_out_valid !== eg) gbad++;
      if (rx_in_ready !== (eg ? k[0] : 1'b1)) gbad++;
      if (eg && rx_out_data !== DW'(k * 3 + 7)) gbad++;
    end
    @(negedge clk); #1;
    check(prt_strobe == exp_next, "R1", "strobe after PRT cycles", prt_strobe, exp_next);
    check(sbad == 0, "R1", "strobe outside phase 0", sbad, 0);
    check(tbad == 0, "R2", "trigger window mismatches", tbad, 0);
    check(gbad == 0, "R3/R4", "gate and stream mismatches", gbad, 0);
    check(ibad == 0, "R5", "irq outside phase 0", ibad, 0);
  endtask

  task automatic t_reset();
    #1;
    check({prt_strobe, amp_trig, rx_gate, irq, irq_flag, cfg_error} == 6'b0,
          "R9", "outputs after reset", {prt_strobe, amp_trig, rx_gate, irq}, 0);
    check(xfer_len == 0, "R9", "xfer_len after reset", xfer_len, 0);
  endtask

  task automatic t_basic_groups();
    wr(3'd0, 20); wr(3'd1, 2); wr(3'd2, 3); wr(3'd3, 5); wr(3'd4, 8); wr(3'd5, 3);
    wr(3'd6, 1);
    wait_strobe();
    measure_pulse(1'b0, 3'd0, 0, 1'b1, 24, 1'b1);   // pulse 0
    measure_pulse(1'b0, 3'd0, 0, 1'b0, 24, 1'b1);   // pulse 1
    measure_pulse(1'b0, 3'd0, 0, 1'b0, 24, 1'b1);   // pulse 2
    measure_pulse(1'b1, 3'd1, 4, 1'b1, 24, 1'b1);   // R8: offset write mid-pulse
    e_toff = 4;
    measure_pulse(1'b0, 3'd0, 0, 1'b0, 24, 1'b1);   // pulse 4 uses new offset
  endtask

  task automatic t_filter();
    measure_pulse(1'b1, 3'd6, 3, 1'b0, 24, 1'b1);   // R8: filter staged, xfer still 24
    measure_pulse(1'b0, 3'd0, 0, 1'b1, 3, 1'b1);    // R7: 3 * floor(8/6)
  endtask

  task automatic t_stop_and_flag();
    measure_pulse(1'b1, 3'd6, 2, 1'b0, 3, 1'b0);    // R9: run cleared mid-pulse
    idle_window(50, "R9", "activity after stop");
    check(irq_flag == 1'b1, "R6", "flag held after irq", irq_flag, 1);
    wr(3'd7, 0);
    #1 check(irq_flag == 1'b1, "R6", "flag after writing 0", irq_flag, 1);
    wr(3'd7, 1);
    #1 check(irq_flag == 1'b0, "R6", "flag after writing 1", irq_flag, 0);
  endtask

  task automatic t_restart();
    wr(3'd6, 1);
    wait_strobe();
    measure_pulse(1'b0, 3'd0, 0, 1'b1, 24, 1'b1);   // R5: group restarts at 0
    measure_pulse(1'b0, 3'd0, 0, 1'b0, 24, 1'b1);
  endtask

  task automatic t_error();
    measure_pulse(1'b1, 3'd6, 0, 1'b0, 24, 1'b0);
    wr(3'd1, 18); wr(3'd2, 5);
    wr(3'd6, 1);
    repeat (3) @(negedge clk);
    #1 check(cfg_error == 1'b1, "R10", "cfg_error on illegal trigger", cfg_error, 1);
    idle_window(60, "R10", "outputs while illegal");
    wr(3'd6, 0);
    repeat (30) @(negedge clk);
    wr(3'd1, 2); wr(3'd2, 3);
    e_toff = 2;
    wr(3'd6, 1);
    wait_strobe();
    check(cfg_error == 1'b0, "R10", "cfg_error after fix", cfg_error, 0);
    measure_pulse(1'b0, 3'd0, 0, 1'b1, 24, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_groups();
    t_filter();
    t_stop_and_flag();
    t_restart();
    t_error();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule